// File: doc/BRIEF.md
# Word Stack Pointer Sequencer

This block keeps a 16-bit stack pointer for a downward-growing word stack and turns single push and pop requests into short access sequences on a synchronous data memory port. The pointer always names the most recently filled word. A push moves the pointer down by two bytes and then writes the operand at the new address. A pop reads the word at the current address and then moves the pointer up by two.

A register file can overwrite the pointer directly. The low address bit is dropped on every store, so the pointer stays word-aligned. Only one operation runs at a time, and `busy_o` covers it. Requests that collide in one idle cycle are rejected with a single-cycle `err_o`. A sticky flag records a push that carried the pointer below address zero.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp_o` equals `TOP_OF_STACK` with bit 0 cleared (default 0x0A00). `busy_o`, `wrap_o`, `err_o`, `mem_we_o`, `mem_re_o` and `pop_valid_o` are all low.
- R2: A push (`push_i`=1, `pop_i`=0, `sp_we_i`=0) is accepted in an idle cycle. `sp_o` drops by 2 at the following clock edge. During the next cycle only, `mem_we_o`=1, `mem_addr_o` equals the new `sp_o`, `mem_wdata_o` holds the pushed data and `busy_o`=1.
- R3: A pop accepted in an idle cycle issues one read in the next cycle (`mem_re_o`=1, `mem_addr_o` equal to the unchanged `sp_o`, `busy_o`=1). `sp_o` rises by 2 at the edge that ends that read cycle.
- R4: In the cycle right after the read cycle, `pop_valid_o` is high for one cycle and `pop_data_o` carries `mem_rdata_i`. The memory returns read data one cycle after `mem_re_o`. Outside that cycle, `pop_data_o` is zero.
- R5: A direct write (`sp_we_i`=1) in an idle cycle with no request stores `sp_wdata_i` with bit 0 cleared at the next edge. It also clears `wrap_o`.
- R6: `push_i` and `pop_i` high together in an idle cycle raise `err_o` in that same cycle. Neither operation is started and `sp_o` is unchanged.
- R7: `sp_we_i` high together with a push or pop in an idle cycle applies the write, drops the request and raises `err_o` in that cycle.
- R8: While `busy_o` is high, `push_i`, `pop_i` and `sp_we_i` have no effect and `err_o` stays low.
- R9: A push accepted while `sp_o` is below 2 wraps the pointer modulo 2^16 (0 becomes 0xFFFE) and sets `wrap_o`. `wrap_o` stays set until a direct write. A push from 2 or above leaves it unchanged.
- R10: Bit 0 of `sp_o` is always zero, and `mem_we_o` and `mem_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 16 | Word to push |
| sp_we_i | input | 1 | Direct pointer write strobe |
| sp_wdata_i | input | 16 | Direct pointer write value |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 16 | Memory read data, one cycle after read enable |
| pop_data_o | output | 16 | Popped word |
| pop_valid_o | output | 1 | Popped word valid, one-cycle pulse |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | Request rejected this cycle |
| wrap_o | output | 1 | Sticky flag: a push wrapped below zero |

## Verification
Two collisions can land in one cycle: the two stack requests together, and a register-file pointer write together with a stack request. The bench drives each pair on the same idle cycle and expects `err_o` in that cycle. In the next cycle it expects no memory access and a pointer that is either unchanged or equal to the written value. A third case drives a pop and a pointer write during a push's write cycle. The bench then checks that no read follows, `err_o` stays low and the pointer reflects only the push.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH_WR  = 2'd1,
    ST_POP_RD   = 2'd2,
    ST_POP_DONE = 2'd3
  } sp_state_e;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      sp_we_i,
  output sp_state_e state_o,
  output logic      push_go_o,
  output logic      pop_go_o,
  output logic      wr_go_o,
  output logic      inc_o,
  output logic      busy_o,
  output logic      err_o
);
  sp_state_e state_q, state_d;
  logic idle;

  assign idle      = (state_q == ST_IDLE);
  assign wr_go_o   = idle & sp_we_i;
  assign push_go_o = idle & push_i & ~pop_i & ~sp_we_i;
  assign pop_go_o  = idle & pop_i & ~push_i & ~sp_we_i;
  assign err_o     = idle & ((push_i & pop_i) | (sp_we_i & (push_i | pop_i)));
  assign inc_o     = (state_q == ST_POP_RD);
  assign busy_o    = ~idle;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (push_go_o)     state_d = ST_PUSH_WR;
        else if (pop_go_o) state_d = ST_POP_RD;
      end
      ST_PUSH_WR:  state_d = ST_IDLE;
      ST_POP_RD:   state_d = ST_POP_DONE;
      ST_POP_DONE: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R6: colliding requests leave the sequencer idle
  a_r6_conflict_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && push_i && pop_i) |=> (state_q == ST_IDLE));

  // R8: no error is reported while an operation runs
  a_r8_no_err_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !err_o);

  // R3: a read cycle is always followed by the data cycle
  a_r3_read_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POP_RD) |=> (state_q == ST_POP_DONE));
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
  parameter int unsigned        AW           = 16,
  parameter logic [AW-1:0]      TOP_OF_STACK = 16'h0A00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] sp_o,
  output logic          wrap_o
);
  // pointer kept in word units; byte bit 0 is a constant zero
  localparam int unsigned  WW     = AW - 1;
  localparam logic [WW-1:0] RST_W = TOP_OF_STACK[AW-1:1];

  logic [WW-1:0] sp_w_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_w_q <= RST_W;
      wrap_q <= 1'b0;
    end else if (wr_i) begin
      sp_w_q <= wdata_i[AW-1:1];
      wrap_q <= 1'b0;
    end else if (dec_i) begin
      sp_w_q <= sp_w_q - WW'(1);
      if (sp_w_q == '0) wrap_q <= 1'b1;
    end else if (inc_i) begin
      sp_w_q <= sp_w_q + WW'(1);
    end
  end

  assign sp_o   = {sp_w_q, 1'b0};
  assign wrap_o = wrap_q;

  // R5: direct write stored with bit 0 cleared
  a_r5_write_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (sp_o == {$past(wdata_i[AW-1:1]), 1'b0}));

  // R9: push from below 2 sets the wrap flag
  a_r9_wrap_on_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !wr_i && (sp_o < AW'(2))) |=> wrap_o);

  // R9: wrap flag is sticky without a direct write
  a_r9_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !wr_i) |=> wrap_o);
endmodule

// File: rtl/sp_mem_if.sv
module sp_mem_if
  import sp_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sp_state_e     state_i,
  input  logic          push_go_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o
);
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wdata_q <= '0;
    else if (push_go_i) wdata_q <= push_data_i;
  end

  // address follows the pointer: already lowered on push, not yet raised on pop
  assign mem_addr_o  = sp_i;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = (state_i == ST_PUSH_WR);
  assign mem_re_o    = (state_i == ST_POP_RD);
  assign pop_valid_o = (state_i == ST_POP_DONE);
  assign pop_data_o  = pop_valid_o ? mem_rdata_i : '0;

  // R4: valid pulse one cycle after the read
  a_r4_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (pop_valid_o && !mem_re_o));

  // R4: the valid strobe lasts a single cycle
  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |=> !pop_valid_o);

  // R10: never read and write together
  a_r10_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int unsigned   AW           = 16,
  parameter int unsigned   DW           = 16,
  parameter logic [AW-1:0] TOP_OF_STACK = 16'h0A00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          sp_we_i,
  input  logic [AW-1:0] sp_wdata_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          busy_o,
  output logic          err_o,
  output logic          wrap_o
);
  sp_state_e state;
  logic push_go, pop_go, wr_go, inc;

  sp_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .sp_we_i   (sp_we_i),
    .state_o   (state),
    .push_go_o (push_go),
    .pop_go_o  (pop_go),
    .wr_go_o   (wr_go),
    .inc_o     (inc),
    .busy_o    (busy_o),
    .err_o     (err_o)
  );

  sp_reg #(.AW(AW), .TOP_OF_STACK(TOP_OF_STACK)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (push_go),
    .inc_i   (inc),
    .wr_i    (wr_go),
    .wdata_i (sp_wdata_i),
    .sp_o    (sp_o),
    .wrap_o  (wrap_o)
  );

  sp_mem_if #(.AW(AW), .DW(DW)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .push_go_i   (push_go),
    .push_data_i (push_data_i),
    .sp_i        (sp_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o)
  );

  // R2: accepted push lowers the pointer, then writes there
  a_r2_push_dec_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !sp_we_i && !busy_o)
      |=> (mem_we_o && (sp_o == AW'($past(sp_o) - AW'(2))) && (mem_addr_o == sp_o)));

  // R3: the pointer rises by 2 after the read
  a_r3_pop_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (sp_o == AW'($past(sp_o) + AW'(2))));

  // R8: pointer is untouched during the write cycle
  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(sp_o));

  // R10: pointer stays word-aligned
  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o[0] == 1'b0);
endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, sp_we_i = 1'b0;
  logic [15:0] push_data_i = '0, sp_wdata_i = '0;
  logic [15:0] sp_o, mem_addr_o, mem_wdata_o, pop_data_o;
  logic [15:0] mem_rdata = '0;
  logic        mem_we_o, mem_re_o, pop_valid_o, busy_o, err_o, wrap_o;
  logic [15:0] mem [0:255];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stack_ptr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata),
    .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o), .busy_o(busy_o),
    .err_o(err_o), .wrap_o(wrap_o)
  );

  // synchronous memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[8:1]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata <= mem[mem_addr_o[8:1]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_push(input logic [15:0] d, input logic [15:0] exp_sp, input string tag);
    @(negedge clk); push_i = 1'b1; push_data_i = d;
    @(negedge clk); push_i = 1'b0;
    chk({tag, " R2 we"}, mem_we_o, 1);
    chk({tag, " R2 addr"}, mem_addr_o, exp_sp);
    chk({tag, " R2 wdata"}, mem_wdata_o, d);
    chk({tag, " R2 busy"}, busy_o, 1);
    chk({tag, " R10 no read"}, mem_re_o, 0);
    @(negedge clk);
    chk({tag, " R2 sp"}, sp_o, exp_sp);
    chk({tag, " R2 idle"}, busy_o, 0);
  endtask

  task automatic do_pop(input logic [15:0] exp_d, input logic [15:0] exp_sp, input string tag);
    @(negedge clk); pop_i = 1'b1;
    @(negedge clk); pop_i = 1'b0;
    chk({tag, " R3 re"}, mem_re_o, 1);
    chk({tag, " R3 addr"}, mem_addr_o, 16'(exp_sp - 16'd2));
    chk({tag, " R3 sp held"}, sp_o, 16'(exp_sp - 16'd2));
    chk({tag, " R10 no write"}, mem_we_o, 0);
    @(negedge clk);
    chk({tag, " R4 valid"}, pop_valid_o, 1);
    chk({tag, " R4 data"}, pop_data_o, exp_d);
    chk({tag, " R3 sp"}, sp_o, exp_sp);
    @(negedge clk);
    chk({tag, " R4 pulse"}, pop_valid_o, 0);
    chk({tag, " R4 data idle"}, pop_data_o, 0);
    chk({tag, " R3 idle"}, busy_o, 0);
  endtask

  task automatic do_write(input logic [15:0] v);
    @(negedge clk); sp_we_i = 1'b1; sp_wdata_i = v;
    @(negedge clk); sp_we_i = 1'b0;
  endtask

  // {op(1=push,2=pop), data, expected sp, expected popped word}
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 16'h1111, 16'h09FE, 16'h0000},
    {2'd1, 16'h2222, 16'h09FC, 16'h0000},
    {2'd1, 16'h3333, 16'h09FA, 16'h0000},
    {2'd2, 16'h0000, 16'h09FC, 16'h3333},
    {2'd1, 16'h4444, 16'h09FA, 16'h0000},
    {2'd2, 16'h0000, 16'h09FC, 16'h4444},
    {2'd2, 16'h0000, 16'h09FE, 16'h2222},
    {2'd2, 16'h0000, 16'h0A00, 16'h1111}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp reset", sp_o, 16'h0A00);
    chk("R1 busy", busy_o, 0);
    chk("R1 wrap", wrap_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 mem idle", {mem_we_o, mem_re_o, pop_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp after release", sp_o, 16'h0A00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49:48] == 2'd1) do_push(VEC[i][47:32], VEC[i][31:16], $sformatf("vec%0d", i));
      else                       do_pop(VEC[i][15:0], VEC[i][31:16], $sformatf("vec%0d", i));
    end

    // R6: push and pop together in idle
    @(negedge clk); push_i = 1'b1; pop_i = 1'b1; #1;
    chk("R6 err", err_o, 1);
    @(negedge clk); push_i = 1'b0; pop_i = 1'b0; #1;
    chk("R6 no start", {busy_o, mem_we_o, mem_re_o}, 0);
    chk("R6 sp kept", sp_o, 16'h0A00);
    chk("R6 err cleared", err_o, 0);

    // R5: odd direct write loses bit 0
    do_write(16'h1235);
    chk("R5 aligned write", sp_o, 16'h1234);

    // R7: direct write with a push in idle
    @(negedge clk); sp_we_i = 1'b1; sp_wdata_i = 16'h0200; push_i = 1'b1; #1;
    chk("R7 err", err_o, 1);
    @(negedge clk); sp_we_i = 1'b0; push_i = 1'b0; #1;
    chk("R7 write wins", sp_o, 16'h0200);
    chk("R7 request dropped", {busy_o, mem_we_o}, 0);

    // R8: requests and writes during a push are ignored
    @(negedge clk); push_i = 1'b1; push_data_i = 16'hBEEF;
    @(negedge clk); push_i = 1'b0; pop_i = 1'b1; sp_we_i = 1'b1; sp_wdata_i = 16'h0100; #1;
    chk("R8 no err while busy", err_o, 0);
    @(negedge clk); pop_i = 1'b0; sp_we_i = 1'b0; #1;
    chk("R8 no read", mem_re_o, 0);
    chk("R8 sp", sp_o, 16'h01FE);
    chk("R8 idle", busy_o, 0);
    do_pop(16'hBEEF, 16'h0200, "R8 pop back");

    // R9: wrap below zero, then clear and edge cases
    do_write(16'h0000);
    do_push(16'hA5A5, 16'hFFFE, "R9 wrap");
    chk("R9 wrap set", wrap_o, 1);
    do_pop(16'hA5A5, 16'h0000, "R9 sticky pop");
    chk("R9 still set", wrap_o, 1);
    do_write(16'h0004);
    chk("R9 cleared by write", wrap_o, 0);
    do_push(16'h0101, 16'h0002, "R9 from4");
    chk("R9 no wrap at 4", wrap_o, 0);
    do_push(16'h0202, 16'h0000, "R9 from2");
    chk("R9 no wrap at 2", wrap_o, 0);
    do_push(16'h0303, 16'hFFFE, "R9 from0");
    chk("R9 wrap at 0", wrap_o, 1);
    chk("R10 bit0", sp_o[0], 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule